// File: doc/BRIEF.md
# Parallel Early-Reject Nonce Search

This unit hunts for a 32-bit nonce that makes the compression of a fixed 512-bit block produce a digest whose top bits are zero. The block is loaded one bit per clock into a shift register. A start command takes the nonce field from the loaded block and clears its low lane bits to form the base. The unit then runs rounds. In each round it presents `LANES` copies of the block to an external compression engine. The copies are identical except for the nonce field, which holds base plus lane index. The unit then waits for that engine to return one digest per lane.

Every returned digest first meets a single probe bit, bit 224. A digest with a 1 there is thrown away without looking at anything else. Only digests with a 0 in the probe bit get the full test: the requested number of leading digest bits must be zero. The lowest-indexed lane that passes wins. The unit latches its nonce, raises `found` and stops. If no lane wins, the base advances by `LANES` and a new round starts. If advancing would carry past 0xFFFFFFFF, the unit raises `exhausted` instead and stops. Two counters report how many digests were vetoed by the probe and how many reached the full compare.

The engine sits behind a go/done handshake, so a behavioural model, a pipelined core or a test harness can serve it.

Top module: `nonce_search`

## Requirements
- R1: After reset `found`, `exhausted`, `busy` and `hashGo` are 0, and both counters are 0.
- R2: While `busy` is 0, each cycle with `shiftEn` high shifts the block: new = {old[510:0], shiftBit}. Every lane's output block equals this register, except for the 32-bit nonce field at bits `NONCE_LSB+31:NONCE_LSB`, LSB at `NONCE_LSB`. Lane k occupies `hashBlocks[k*512 +: 512]`.
- R3: `start` while idle sets the base to the loaded nonce field with its low log2(`LANES`) bits cleared. Lane k carries nonce base+k.
- R4: `hashGo` is a one-cycle pulse in the cycle after a start, and in the cycle after each round that neither hits nor exhausts. Lane blocks stay constant until `hashDone`.
- R5: A lane whose digest has bit 224 set is rejected, whatever its other bits hold.
- R6: A lane hits when digest bit 224 is 0 and digest bits 255 down to 256-`zeroBits` are all 0. `zeroBits` ranges from 1 to 64. Lane k's digest is `hashDigests[k*256 +: 256]`.
- R7: On a round with hits, the lowest-indexed hitting lane wins. `winNonce` takes base+k, `found` rises and `busy` falls in the cycle after `hashDone`.
- R8: A round without hits on a non-final base advances the base by `LANES` and issues a new round.
- R9: A round without hits whose base+`LANES` exceeds 0xFFFFFFFF raises `exhausted` and stops; `found` stays 0.
- R10: On each evaluated round, `rejectCount` grows by the number of lanes with bit 224 set and `compareCount` by the remaining lanes. `start` clears both.
- R11: While `busy`, `shiftEn` and `start` have no effect. Outside a round wait, `hashDone` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shiftEn | input | 1 | Shift one block bit in |
| shiftBit | input | 1 | Serial block bit |
| start | input | 1 | Begin a search from the loaded nonce |
| zeroBits | input | 7 | Required leading zero digest bits (1..64) |
| hashGo | output | 1 | Round request pulse to the compression engine |
| hashBlocks | output | LANES*512 | Per-lane blocks with lane nonce inserted |
| hashDone | input | 1 | Engine has placed all lane digests |
| hashDigests | input | LANES*256 | Per-lane digests |
| busy | output | 1 | A search is in progress |
| found | output | 1 | A winning nonce was latched |
| exhausted | output | 1 | Nonce space ran out without a hit |
| winNonce | output | 32 | Winning nonce |
| rejectCount | output | CNT_W | Lanes vetoed by the probe bit |
| compareCount | output | CNT_W | Lanes given the full compare |

## Verification
The cases hardest to reach from the ports are the exits at the edge of the nonce space and the probe veto. Exhaustion needs the base to sit at the last aligned group below the 32-bit wrap. A veto needs a digest whose leading bits satisfy the target while bit 224 is still set. Loading a block with its nonce field near 0xFFFFFFFF reaches the wrap in one or two rounds. The bench acts as the compression engine and injects digests chosen bit by bit, so each probe outcome, each zero-count boundary and each lane priority is forced directly rather than searched for.

// File: rtl/nonce_search_pkg.sv
package nonce_search_pkg;

  typedef struct packed {
    logic loadBase;
    logic stepBase;
    logic evalRound;
    logic hold;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } srchState_t;

endpackage

// File: rtl/nonce_search_datapath.sv
module nonce_search_datapath
  import nonce_search_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int NONCE_LSB = 96,
  parameter int PROBE_BIT = 224,
  parameter int CNT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobes_t            ctl,
  input  logic                   shiftEn,
  input  logic                   shiftBit,
  input  logic [6:0]             zeroBits,
  input  logic [LANES*256-1:0]   hashDigests,
  output logic [LANES*512-1:0]   hashBlocks,
  output logic                   anyHit,
  output logic                   lastRound,
  output logic [31:0]            winNonce,
  output logic [CNT_W-1:0]       rejectCount,
  output logic [CNT_W-1:0]       compareCount
);
  localparam int BLK_W = 512;
  localparam int DIG_W = 256;
  localparam logic [31:0] LANE_MASK = 32'(LANES - 1);

  logic [BLK_W-1:0] blockReg;
  logic [31:0]      baseNonce;
  logic [32:0]      nextBase;
  logic [63:0]      topMask;
  logic [LANES-1:0] probeOne;
  logic [LANES-1:0] laneHit;
  logic [31:0]      winOffset;
  logic             unusedDigestBits;

  assign nextBase  = {1'b0, baseNonce} + 33'(LANES);
  assign lastRound = nextBase[32];
  assign topMask   = ~({64{1'b1}} >> zeroBits);
  assign unusedDigestBits = ^hashDigests;

  always_ff @(posedge clk) begin
    if (!rstN) blockReg <= '0;
    else if (shiftEn && !ctl.hold) blockReg <= {blockReg[BLK_W-2:0], shiftBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) baseNonce <= '0;
    else if (ctl.loadBase) baseNonce <= blockReg[NONCE_LSB +: 32] & ~LANE_MASK;
    else if (ctl.stepBase) baseNonce <= nextBase[31:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BLK_W-1:0] laneBlk;
    logic [DIG_W-1:0] laneDig;
    always_comb begin
      laneBlk = blockReg;
      laneBlk[NONCE_LSB +: 32] = baseNonce + 32'(g);
    end
    assign hashBlocks[g*BLK_W +: BLK_W] = laneBlk;
    assign laneDig     = hashDigests[g*DIG_W +: DIG_W];
    assign probeOne[g] = laneDig[PROBE_BIT];
    assign laneHit[g]  = !laneDig[PROBE_BIT] && ((laneDig[DIG_W-1 -: 64] & topMask) == '0);
  end

  assign anyHit = |laneHit;

  always_comb begin
    winOffset = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (laneHit[k]) winOffset = 32'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.loadBase) begin
      rejectCount  <= '0;
      compareCount <= '0;
      winNonce     <= '0;
    end else if (ctl.evalRound) begin
      rejectCount  <= rejectCount + CNT_W'($countones(probeOne));
      compareCount <= compareCount + CNT_W'(LANES - $countones(probeOne));
      if (anyHit) winNonce <= baseNonce + winOffset;
    end
  end

  // R11: the block register cannot move while a search holds it
  a_r11_block_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> $stable(blockReg));

  // R10: every evaluated round accounts for exactly LANES digests
  a_r10_count_total: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.evalRound && !ctl.loadBase) |=>
      CNT_W'((rejectCount - $past(rejectCount)) + (compareCount - $past(compareCount))) == CNT_W'(LANES));

  // R3: lane 0 always carries an aligned base
  a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |-> ((hashBlocks[NONCE_LSB +: 32] & LANE_MASK) == '0));

endmodule

// File: rtl/nonce_search_ctrl.sv
module nonce_search_ctrl
  import nonce_search_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        hashDone,
  input  logic        anyHit,
  input  logic        lastRound,
  output ctlStrobes_t ctl,
  output logic        hashGo,
  output logic        busy,
  output logic        found,
  output logic        exhausted
);
  srchState_t state, nextState;

  always_comb begin
    ctl       = '0;
    hashGo    = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        ctl.loadBase = 1'b1;
        nextState    = ST_ISSUE;
      end
      ST_ISSUE: begin
        hashGo    = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: if (hashDone) begin
        ctl.evalRound = 1'b1;
        if (anyHit || lastRound) nextState = ST_IDLE;
        else begin
          ctl.stepBase = 1'b1;
          nextState    = ST_ISSUE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    ctl.hold = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      found     <= 1'b0;
      exhausted <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.loadBase) begin
        found     <= 1'b0;
        exhausted <= 1'b0;
      end else if (ctl.evalRound) begin
        if (anyHit)         found     <= 1'b1;
        else if (lastRound) exhausted <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // R4: a round request never lasts two cycles
  a_r4_go_single: assert property (@(posedge clk) disable iff (!rstN)
    hashGo |=> !hashGo);

  // R9: a search ends one way only
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(found && exhausted));

  // R7: a latched hit leaves the unit idle
  a_r7_found_idle: assert property (@(posedge clk) disable iff (!rstN)
    found |-> !busy);

  // R11: start during a search does not reload the base
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.loadBase);

endmodule

// File: rtl/nonce_search.sv
module nonce_search
  import nonce_search_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int NONCE_LSB = 96,
  parameter int PROBE_BIT = 224,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 shiftEn,
  input  logic                 shiftBit,
  input  logic                 start,
  input  logic [6:0]           zeroBits,
  output logic                 hashGo,
  output logic [LANES*512-1:0] hashBlocks,
  input  logic                 hashDone,
  input  logic [LANES*256-1:0] hashDigests,
  output logic                 busy,
  output logic                 found,
  output logic                 exhausted,
  output logic [31:0]          winNonce,
  output logic [CNT_W-1:0]     rejectCount,
  output logic [CNT_W-1:0]     compareCount
);
  ctlStrobes_t ctl;
  logic        anyHit;
  logic        lastRound;

  nonce_search_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .hashDone(hashDone),
    .anyHit(anyHit), .lastRound(lastRound), .ctl(ctl), .hashGo(hashGo),
    .busy(busy), .found(found), .exhausted(exhausted)
  );

  nonce_search_datapath #(
    .LANES(LANES), .NONCE_LSB(NONCE_LSB), .PROBE_BIT(PROBE_BIT), .CNT_W(CNT_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shiftEn(shiftEn), .shiftBit(shiftBit),
    .zeroBits(zeroBits), .hashDigests(hashDigests), .hashBlocks(hashBlocks),
    .anyHit(anyHit), .lastRound(lastRound), .winNonce(winNonce),
    .rejectCount(rejectCount), .compareCount(compareCount)
  );

endmodule

// File: tb/test_nonce_search.sv
module test_nonce_search;
  localparam int LANES = 4;
  localparam int NLSB  = 96;
  localparam int CW    = 16;

  typedef struct packed {
    logic [31:0] startNonce;
    logic [6:0]  zb;
    logic [63:0] t0, t1, t2, t3;
    logic        expFound;
    logic [1:0]  expLane;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_1000, 7'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_7000_0000_0000,
      64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd1},
    '{32'h2000_0005, 7'd8, 64'h00FF_FFFE_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
      64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd0},
    '{32'hFFFF_FFFC, 7'd8, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000,
      64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 1'b0, 2'd0},
    '{32'h0000_0040, 7'd64, 64'h1, 64'h1, 64'h1, 64'h0, 1'b1, 2'd3},
    '{32'hFFFF_FFFC, 7'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
      64'h7FFF_FFFE_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 2'd2},
    '{32'h0000_0100, 7'd33, 64'h0000_0000_8000_0000, 64'h0000_0000_4000_0000,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 2'd1}
  };

  logic clk = 0, rstN = 0, shiftEn = 0, shiftBit = 0, start = 0, hashDone = 0;
  logic [6:0] zeroBits = 7'd8;
  logic hashGo, busy, found, exhausted;
  logic [LANES*512-1:0] hashBlocks;
  logic [LANES*256-1:0] hashDigests = '0;
  logic [31:0] winNonce;
  logic [CW-1:0] rejectCount, compareCount;

  int checks = 0, fails = 0;
  logic [511:0] img;

  always #4 clk = ~clk;

  nonce_search #(.LANES(LANES), .NONCE_LSB(NLSB), .PROBE_BIT(224), .CNT_W(CW)) i_nonce_search (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .shiftBit(shiftBit), .start(start),
    .zeroBits(zeroBits), .hashGo(hashGo), .hashBlocks(hashBlocks), .hashDone(hashDone),
    .hashDigests(hashDigests), .busy(busy), .found(found), .exhausted(exhausted),
    .winNonce(winNonce), .rejectCount(rejectCount), .compareCount(compareCount)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] withNonce(input logic [511:0] b, input logic [31:0] n);
    logic [511:0] r = b;
    r[NLSB +: 32] = n;
    return r;
  endfunction

  function automatic logic [LANES*256-1:0] mkDig(input logic [63:0] a, b, c, d);
    logic [191:0] fill = {6{32'hA5C3_5A3C}};
    return {d, fill, c, fill, b, fill, a, fill};
  endfunction

  function automatic int probes(input logic [63:0] a, b, c, d);
    return int'(a[32]) + int'(b[32]) + int'(c[32]) + int'(d[32]);
  endfunction

  task automatic loadBlock(input logic [511:0] blk);
    for (int k = 0; k < 512; k++) begin
      @(negedge clk); shiftEn = 1; shiftBit = blk[511-k];
    end
    @(negedge clk); shiftEn = 0;
    img = blk;
  endtask

  task automatic startSearch();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic waitGo();
    while (!hashGo) @(negedge clk);
  endtask

  task automatic respond(input logic [LANES*256-1:0] d);
    @(negedge clk); hashDigests = d; hashDone = 1;
    @(negedge clk); hashDone = 0;
  endtask

  task automatic laneCheck(input logic [31:0] base, input string tag);
    for (int k = 0; k < LANES; k++) begin
      logic [511:0] exp = withNonce(img, base + 32'(k));
      check(hashBlocks[k*512 +: 512] == exp, tag,
            hashBlocks[k*512 + NLSB +: 32], exp[NLSB +: 32]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!found && !exhausted && !busy && !hashGo, "R1 flags", {found, exhausted, busy, hashGo}, 0);
    check(rejectCount == 0 && compareCount == 0, "R1 counters", {rejectCount, compareCount}, 0);

    // table of single-round searches
    for (int v = 0; v < 6; v++) begin
      vec_t t = VECS[v];
      logic [31:0] base = t.startNonce & ~32'(LANES - 1);
      int rj = probes(t.t0, t.t1, t.t2, t.t3);
      zeroBits = t.zb;
      loadBlock(withNonce({16{32'h1357_9BDF ^ 32'(v * 32'h0101_0101)}}, t.startNonce));
      startSearch();
      // R2 R3 lane blocks and aligned base, R4 request pulse
      check(hashGo && busy && !found && !exhausted, "R4 go after start", {hashGo, busy, found, exhausted}, 4'b1100);
      laneCheck(base, "R3 lane nonce");
      waitGo();
      respond(mkDig(t.t0, t.t1, t.t2, t.t3));
      check(found == t.expFound, "R6 R5 found", found, t.expFound);
      check(exhausted == !t.expFound, "R9 exhausted", exhausted, !t.expFound);
      check(!busy, "R7 stop", busy, 0);
      if (t.expFound)
        check(winNonce == base + 32'(t.expLane), "R7 win nonce", winNonce, base + 32'(t.expLane));
      check(rejectCount == CW'(rj), "R10 rejects", rejectCount, rj);
      check(compareCount == CW'(LANES - rj), "R10 compares", compareCount, LANES - rj);
    end

    // R8 multi-round stepping, R4 single pulse
    zeroBits = 7'd4;
    loadBlock(withNonce({16{32'hC0DE_F00D}}, 32'h0));
    startSearch();
    waitGo();
    @(negedge clk);
    check(!hashGo, "R4 pulse width", hashGo, 0);
    respond(mkDig({4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFF}}));
    check(busy && !found && hashGo, "R8 next round", {busy, found, hashGo}, 3'b101);
    laneCheck(32'h4, "R8 stepped base");
    respond(mkDig({4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFF}}, 64'h0));
    check(found && winNonce == 32'h7, "R8 R7 second round win", winNonce, 32'h7);
    check(rejectCount == 7 && compareCount == 1, "R10 cumulative", {rejectCount, compareCount}, {16'd7, 16'd1});

    // R11 hashDone while idle has no effect
    @(negedge clk); hashDigests = '0; hashDone = 1;
    @(negedge clk); hashDone = 0;
    check(rejectCount == 7 && compareCount == 1 && winNonce == 32'h7 && !busy,
          "R11 stray done", {rejectCount, compareCount}, {16'd7, 16'd1});

    // R9 exhaustion across two rounds
    loadBlock(withNonce({16{32'h0F1E_2D3C}}, 32'hFFFF_FFF9));
    startSearch();
    laneCheck(32'hFFFF_FFF8, "R3 masked base");
    waitGo();
    respond(mkDig({4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFF}}));
    check(busy && !exhausted, "R9 not yet", {busy, exhausted}, 2'b10);
    waitGo();
    respond(mkDig({4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFF}}));
    check(exhausted && !found && !busy, "R9 wrap stop", {exhausted, found, busy}, 3'b100);
    check(rejectCount == 8, "R10 after wrap", rejectCount, 8);

    // R11 shift and start ignored while busy
    zeroBits = 7'd8;
    loadBlock(withNonce({16{32'h2468_ACE0}}, 32'h0000_0020));
    startSearch();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); shiftEn = 1; shiftBit = 1; start = 1;
    end
    @(negedge clk); shiftEn = 0; start = 0;
    check(busy && !hashGo, "R11 waiting", {busy, hashGo}, 2'b10);
    laneCheck(32'h20, "R11 block frozen");
    respond(mkDig(64'h0, 64'h0, 64'h0, 64'h0));
    check(found && winNonce == 32'h20, "R7 lowest lane wins", winNonce, 32'h20);
    check(compareCount == 4 && rejectCount == 0, "R10 no restart", {rejectCount, compareCount}, 4);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule